// File: doc/BRIEF.md
# DMA Burst Splitter for Paired Memory-Mapped Sides

This block takes one DMA transfer request, a start address and a byte count, and cuts it into a series of memory-mapped bursts for two sides at once: a source (read) side and a destination (write) side. Each side has its own bus width, its own burst-length field width (4 bits for an AXI3 side, 8 bits for an AXI4 side) and its own beat ceiling. A narrow length field on one side therefore never cuts short the length field of the other side.

The largest burst on a side is the smaller of two limits: the configured maximum bytes per burst divided by that side's bytes per beat, and the beat count its length field can express. A configured byte limit that is larger than the bus allows is reduced to the bus limit. Every burst carries a bus-aligned address, a length field holding the beat count minus one, and a flag that marks the final burst of the request. The final burst may be shorter than the others.

Requests come in on a valid/ready handshake. Each side sends its bursts out on its own valid/ready stream. When a side's ready is low, that side holds its burst unchanged and keeps valid high. The two sides never wait on each other. A new request is taken only after both sides have handed off their final burst.

Top module: `burst_split_dual`

## Requirements
- R1: A side's beat cap is min(max(MAX_BYTES / beat bytes, 1), 2^length-field width). Every burst except the last has exactly cap beats. With the default parameters the source cap is 16 beats (a 1024-byte limit on an 8-byte bus is reduced to 16 beats) and the destination cap is 64 beats.
- R2: The length output of a side is beats minus one, in that side's own field width: 4 bits on the source, 8 bits on the destination.
- R3: The first burst address is the request address with the low log2(beat bytes) bits cleared. Each later burst address is the previous address plus the previous burst's beats times the beat bytes. Every burst address is aligned to the bus width.
- R4: The total number of beats on a side is floor((address mod beat bytes + length-minus-one) / beat bytes) + 1. The last flag is high only on the final burst, and that burst carries the remaining beats. The side drops valid in the cycle after the last burst is handed off.
- R5: `req_ready` is high only when neither side has valid high. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. Both sides raise valid in the next cycle.
- R6: While a side's valid is high and its ready is low, valid, address, length and last stay unchanged.
- R7: The two sides are independent. One side can finish its whole burst series while the other side is held by back-pressure.
- R8: After a synchronous active-low reset, both valids are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Byte start address |
| req_len_m1 | input | LEN_W | Byte count minus one |
| src_valid | output | 1 | Source burst offered |
| src_ready | input | 1 | Source burst taken |
| src_addr | output | ADDR_W | Source burst address |
| src_len | output | SRC_LFW | Source beats minus one |
| src_last | output | 1 | Final source burst |
| dst_valid | output | 1 | Destination burst offered |
| dst_ready | input | 1 | Destination burst taken |
| dst_addr | output | ADDR_W | Destination burst address |
| dst_len | output | DST_LFW | Destination beats minus one |
| dst_last | output | 1 | Final destination burst |

## Verification
The bench drives the source side as a 4-bit-field bus whose configured byte limit is larger than that field can carry. If the clamp were missing, the source length field would wrap and the address steps would disagree with the beat counts. The directed cases cover the following:
- A one-byte request.
- An unaligned request that spills into a second source beat but fits in one destination beat. A wrong span count drops or adds a beat here.
- Spans of exactly one cap and of one cap plus one beat. An off-by-one in the last-burst test produces a spurious extra burst or a zero-beat burst.

One side is stalled while the other finishes, which exposes any coupling between the sides. Random ready patterns catch bursts that change while they are stalled.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

  // Beat ceiling of one side: configured byte limit in beats,
  // reduced to what the length field can express.
  function automatic int unsigned burst_cap(int unsigned max_bytes,
                                            int unsigned beat_bytes,
                                            int unsigned len_field_w);
    int unsigned by_cfg;
    int unsigned by_proto;
    by_cfg   = max_bytes / beat_bytes;
    if (by_cfg == 0) by_cfg = 1;
    by_proto = 1 << len_field_w;
    return (by_cfg < by_proto) ? by_cfg : by_proto;
  endfunction

endpackage

// File: rtl/bsplit_span.sv
module bsplit_span #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len_m1,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W:0]    beats
);
  localparam int SH    = $clog2(BEAT_BYTES);
  localparam int CNT_W = LEN_W + 1;

  generate
    if (SH == 0) begin : g_byte_bus
      assign base  = addr;
      assign beats = CNT_W'(len_m1) + CNT_W'(1);
    end else begin : g_wide_bus
      logic [CNT_W-1:0] lo_off;
      assign lo_off = CNT_W'(addr[SH-1:0]);
      assign base   = {addr[ADDR_W-1:SH], {SH{1'b0}}};
      assign beats  = ((lo_off + CNT_W'(len_m1)) >> SH) + CNT_W'(1);
    end
  endgenerate
endmodule

// File: rtl/bsplit_side.sv
module bsplit_side
  import bsplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BEAT_BYTES  = 8,
  parameter int LEN_FIELD_W = 4,
  parameter int MAX_BYTES   = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [ADDR_W-1:0]      load_addr,
  input  logic [LEN_W-1:0]       load_len_m1,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [ADDR_W-1:0]      m_addr,
  output logic [LEN_FIELD_W-1:0] m_len,
  output logic                   m_last
);
  localparam int SH    = $clog2(BEAT_BYTES);
  localparam int CNT_W = LEN_W + 1;
  localparam int CAP   = burst_cap(MAX_BYTES, BEAT_BYTES, LEN_FIELD_W);
  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  span_beats;

  bsplit_span #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_span (
    .addr  (load_addr),
    .len_m1(load_len_m1),
    .base  (start_addr),
    .beats (span_beats)
  );

  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              fits;
  logic [CNT_W-1:0]  cur_beats;
  logic [ADDR_W-1:0] step;
  logic              fire;

  always_comb begin
    fits      = (left_q <= CAP_V);
    cur_beats = fits ? left_q : CAP_V;
    step      = ADDR_W'(cur_beats) << SH;
    fire      = active_q & m_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      left_q   <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      addr_q   <= start_addr;
      left_q   <= span_beats;
    end else if (fire) begin
      addr_q <= addr_q + step;
      left_q <= left_q - cur_beats;
      if (fits) active_q <= 1'b0;
    end
  end

  assign m_valid = active_q;
  assign m_addr  = addr_q;
  assign m_len   = LEN_FIELD_W'(cur_beats - CNT_W'(1));
  assign m_last  = fits;
endmodule

// File: rtl/burst_split_dual.sv
module burst_split_dual #(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 16,
  parameter int MAX_BYTES      = 1024,
  parameter int SRC_BEAT_BYTES = 8,
  parameter int SRC_LFW        = 4,
  parameter int DST_BEAT_BYTES = 16,
  parameter int DST_LFW        = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len_m1,
  output logic               src_valid,
  input  logic               src_ready,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [SRC_LFW-1:0] src_len,
  output logic               src_last,
  output logic               dst_valid,
  input  logic               dst_ready,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [DST_LFW-1:0] dst_len,
  output logic               dst_last
);
  logic take;

  assign req_ready = ~src_valid & ~dst_valid;
  assign take      = req_valid & req_ready;

  bsplit_side #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(SRC_BEAT_BYTES),
    .LEN_FIELD_W(SRC_LFW), .MAX_BYTES(MAX_BYTES)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .load(take),
    .load_addr(req_addr), .load_len_m1(req_len_m1),
    .m_valid(src_valid), .m_ready(src_ready),
    .m_addr(src_addr), .m_len(src_len), .m_last(src_last)
  );

  bsplit_side #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(DST_BEAT_BYTES),
    .LEN_FIELD_W(DST_LFW), .MAX_BYTES(MAX_BYTES)
  ) u_dst (
    .clk(clk), .rst_n(rst_n), .load(take),
    .load_addr(req_addr), .load_len_m1(req_len_m1),
    .m_valid(dst_valid), .m_ready(dst_ready),
    .m_addr(dst_addr), .m_len(dst_len), .m_last(dst_last)
  );
endmodule

// File: rtl/burst_split_chk.sv
module bsplit_side_chk
  import bsplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BEAT_BYTES  = 8,
  parameter int LEN_FIELD_W = 4,
  parameter int MAX_BYTES   = 1024
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load,
  input logic                   m_valid,
  input logic                   m_ready,
  input logic [ADDR_W-1:0]      m_addr,
  input logic [LEN_FIELD_W-1:0] m_len,
  input logic                   m_last
);
  localparam int SH  = $clog2(BEAT_BYTES);
  localparam int CAP = burst_cap(MAX_BYTES, BEAT_BYTES, LEN_FIELD_W);
  localparam logic [LEN_FIELD_W:0] CAP_M1 = (LEN_FIELD_W+1)'(CAP - 1);

  logic [ADDR_W-1:0] stride;
  assign stride = ADDR_W'({1'b0, m_len} + (LEN_FIELD_W+1)'(1)) << SH;

  assert_len_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ({1'b0, m_len} <= CAP_M1));
  assert_full_burst_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |-> ({1'b0, m_len} == CAP_M1));
  assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_addr % ADDR_W'(BEAT_BYTES)) == '0));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !m_last) |=> (m_valid && (m_addr == $past(m_addr) + $past(stride))));
  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last && !load) |=> !m_valid);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_len) && $stable(m_last)));
  assert_no_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !m_valid);
endmodule

module burst_split_top_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic src_valid,
  input logic dst_valid
);
  assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid || dst_valid) |-> !req_ready);
  assert_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (src_valid && dst_valid));
  assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_valid && !dst_valid) |-> req_ready);
endmodule

bind burst_split_dual burst_split_top_chk u_top_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .src_valid(src_valid), .dst_valid(dst_valid)
);

bind bsplit_side bsplit_side_chk #(
  .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES),
  .LEN_FIELD_W(LEN_FIELD_W), .MAX_BYTES(MAX_BYTES)
) u_side_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .m_valid(m_valid), .m_ready(m_ready),
  .m_addr(m_addr), .m_len(m_len), .m_last(m_last)
);

// File: tb/burst_split_dual_tb.sv
module burst_split_dual_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len_m1 = '0;
  logic        src_valid, src_last, dst_valid, dst_last;
  logic [31:0] src_addr, dst_addr;
  logic [3:0]  src_len;
  logic [7:0]  dst_len;
  logic        rdy [2];
  int          rdy_mode [2];

  int n_tests = 0;
  int n_fail  = 0;

  // expected stream state per side: 0 = source, 1 = destination
  int          exp_left [2];
  logic [31:0] exp_addr [2];
  int          cap  [2] = '{16, 64};
  int          bb   [2] = '{8, 16};

  assign src_ready_w = 1'b0;
  logic src_ready_w;

  burst_split_dual u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len_m1(req_len_m1),
    .src_valid(src_valid), .src_ready(rdy[0]), .src_addr(src_addr),
    .src_len(src_len), .src_last(src_last),
    .dst_valid(dst_valid), .dst_ready(rdy[1]), .dst_addr(dst_addr),
    .dst_len(dst_len), .dst_last(dst_last)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic int span_beats(logic [31:0] a, int len_m1, int b);
    return ((int'(a % b) + len_m1) / b) + 1;
  endfunction

  task automatic peek(input int s, output bit v, output logic [31:0] a,
                      output int l, output bit last);
    if (s == 0) begin v = src_valid; a = src_addr; l = int'(src_len); last = src_last; end
    else        begin v = dst_valid; a = dst_addr; l = int'(dst_len); last = dst_last; end
  endtask

  task automatic monitor(input int s);
    bit          v, last, held, h_last;
    logic [31:0] a, h_addr;
    int          l, h_len, beats;
    held = 0;
    forever begin
      @(negedge clk);
      case (rdy_mode[s])
        1:       rdy[s] = 1'b1;
        2:       rdy[s] = 1'b0;
        default: rdy[s] = ($urandom % 10) < 7;
      endcase
      #1;
      peek(s, v, a, l, last);
      if (held && rst_n) begin
        check(v && a == h_addr && l == h_len && last == h_last, "R6",
              "stalled burst changed (addr)", longint'(a), longint'(h_addr));
      end
      held = 0;
      if (v && rst_n) begin
        if (rdy[s]) begin
          beats = (exp_left[s] < cap[s]) ? exp_left[s] : cap[s];
          check(exp_left[s] > 0, "R4", "burst beyond span", exp_left[s], 1);
          check(a == exp_addr[s], "R3", "burst address", longint'(a), longint'(exp_addr[s]));
          check(l == beats - 1, (beats == cap[s]) ? "R1" : "R2", "length field", l, beats - 1);
          check(last == (exp_left[s] <= cap[s]), "R4", "last flag", last, exp_left[s] <= cap[s]);
          exp_addr[s] = exp_addr[s] + 32'(beats * bb[s]);
          exp_left[s] = exp_left[s] - beats;
        end else begin
          held = 1; h_addr = a; h_len = l; h_last = last;
        end
      end
    end
  endtask

  task automatic issue(input logic [31:0] a, input int len_m1);
    do @(negedge clk); while (!req_ready);
    for (int s = 0; s < 2; s++) begin
      exp_left[s] = span_beats(a, len_m1, bb[s]);
      exp_addr[s] = a & ~32'(bb[s] - 1);
    end
    req_addr = a; req_len_m1 = 16'(len_m1); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(!req_ready && src_valid && dst_valid, "R5", "start / ready low",
          req_ready, 0);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!req_ready);
    #1;
    check(exp_left[0] == 0, "R4", "source beats left", exp_left[0], 0);
    check(exp_left[1] == 0, "R4", "dest beats left", exp_left[1], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    rdy[0] = 1'b0; rdy[1] = 1'b0;
    rdy_mode[0] = 2; rdy_mode[1] = 2;
    exp_left[0] = 0; exp_left[1] = 0;
    exp_addr[0] = '0; exp_addr[1] = '0;
    void'($urandom(32'h5EED_0042));
    fork
      monitor(0);
      monitor(1);
    join_none
    repeat (4) @(negedge clk);
    #1;
    check(req_ready && !src_valid && !dst_valid, "R8", "reset state", req_ready, 1);
    rst_n = 1'b1;

    rdy_mode[0] = 1; rdy_mode[1] = 1;
    // one byte at an odd address
    issue(32'h13, 0);          wait_done();
    // unaligned: two source beats, one destination beat
    issue(32'h107, 8);         wait_done();
    // exactly one source cap (16 beats of 8 bytes): clamp from 1024 bytes
    issue(32'h0, 127);         wait_done();
    // one beat over the source cap
    issue(32'h400, 135);       wait_done();
    // large span, destination limited by the byte setting (R1)
    issue(32'h1000, 4095);     wait_done();

    // R7: destination stalled while source runs to completion
    rdy_mode[1] = 2;
    issue(32'h2000, 1023);
    repeat (20) @(negedge clk);
    #1;
    check(!src_valid && exp_left[0] == 0, "R7", "source finished alone", exp_left[0], 0);
    check(dst_valid && exp_left[1] == 64, "R7", "dest untouched", exp_left[1], 64);
    check(!req_ready, "R5", "no accept while dest busy", req_ready, 0);
    rdy_mode[1] = 1;
    wait_done();

    // random traffic with random back-pressure
    rdy_mode[0] = 0; rdy_mode[1] = 0;
    for (int i = 0; i < 60; i++) begin
      issue($urandom & 32'h000F_FFFF, int'($urandom % 3000));
      wait_done();
    end
    finish_run();
  end
endmodule